// File: doc/BRIEF.md
# Dual-output clock prescaler and divider

This block derives two clocks from one master clock, both locked to its rising edges. The reference output carries either the master clock itself or a copy divided by 1, 2, 4 or 8, and a select input picks between the two. The main output goes through its own divide-by-1/2/4/8 prescaler and then a 10-bit programmable divider whose divisor is the stored code plus two. A bypass input skips that divider.

All divisor settings arrive as static register inputs. A new setting is loaded only when the stage that uses it finishes its current output period, so a change while running never cuts a pulse short. Enabling the outputs, tri-state drive, power management and the oscillator that makes the master clock all sit outside this block.

Top module: `clkdiv_dual`

## Requirements
- R1: A prescaler code selects its division ratio as 00 = 1, 01 = 2, 10 = 4 and 11 = 8. After reset both prescalers run with code 00, whatever their code inputs say.
- R2: For a prescaler ratio M of 2 or more, the prescaled clock is high for the first M/2 master cycles of each period and low for the last M/2.
- R3: At ratio 1 a prescaler passes the master clock straight through, with no register in the path. The output therefore follows the master clock high and low inside each cycle.
- R4: With ref_sel_i = 0 the reference output is the master clock. With ref_sel_i = 1 it is the reference prescaler's output.
- R5: With n_bypass_i = 0 the main output period is M x (n_code_i + 2) master cycles, so codes 0 and 1023 give division by 2 and by 1025 of the prescaled clock.
- R6: With n_bypass_i = 0, an even divisor N gives N/2 prescaled periods high and N/2 low. An odd N gives (N+1)/2 high and (N-1)/2 low. The high phase comes first.
- R7: With n_bypass_i = 1 the main output is the main prescaler's output, and n_code_i has no effect on it.
- R8: A prescaler code or divider code written mid-period takes effect only after the period in progress has completed at its old length, both high and low phases.
- R9: The reference code and select have no effect on the main output, and the main-path settings have no effect on the reference output.
- R10: Reset leaves the divider with code 0 (divide-by-2) and its output high. The main output falls on the first edge after reset and rises on the second, when the programmed code is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| ref_code_i | input | 2 | Reference prescaler ratio code |
| ref_sel_i | input | 1 | 1 selects the prescaled clock for the reference output, 0 the master clock |
| main_code_i | input | 2 | Main-path prescaler ratio code |
| n_code_i | input | 10 | Divider code, divisor = code + 2 |
| n_bypass_i | input | 1 | 1 routes the main prescaler output directly to the main output |
| ref_clk_o | output | 1 | Reference clock |
| main_clk_o | output | 1 | Main clock |

## Verification
Several properties are checked on every cycle:
- a loaded code changes only at a terminal count, in both the prescalers and the divider;
- the phase counters never pass the period length that was loaded;
- while the divider is in use, the main output can move only on an edge where the main prescaler completes a period.

Other behaviour shows only over whole periods, so the bench's scenarios cover it: the absolute high and low lengths for each ratio and divisor, the odd-divisor duty split, pass-through following the master clock inside a cycle, the first two periods after reset, and a mid-period code change leaving the current period at its old length.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

  // Width of a prescaler ratio code and of its phase counter.
  localparam int PRE_CW   = 2;
  localparam int PRE_CNTW = (1 << PRE_CW) - 1;

  // Prescaler division ratio for a code: a power of two.
  function automatic int pre_ratio(input int code);
    return 1 << code;
  endfunction

  // Master cycles spent high in one prescaled period.
  function automatic int pre_high(input int code);
    return pre_ratio(code) / 2;
  endfunction

  // Divider ratio: stored code plus two.
  function automatic int n_ratio(input int code);
    return code + 2;
  endfunction

  // Input periods spent high by the divider; the extra one goes high for odd ratios.
  function automatic int n_high(input int code);
    return (n_ratio(code) + 1) / 2;
  endfunction

endpackage

// File: rtl/clkdiv_prescaler.sv
module clkdiv_prescaler
  import clkdiv_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PRE_CW-1:0] code_i,
  output logic              clk_o,
  output logic              tick_o
);

  logic [PRE_CW-1:0]   act_q;
  logic [PRE_CNTW-1:0] cnt_q;
  logic                ph_q;
  logic [PRE_CNTW-1:0] last_w;
  logic [PRE_CNTW-1:0] half_w;
  logic [PRE_CNTW-1:0] cnt_inc_w;

  assign last_w    = PRE_CNTW'(pre_ratio(int'(act_q)) - 1);
  assign half_w    = PRE_CNTW'(pre_high(int'(act_q)));
  assign cnt_inc_w = cnt_q + PRE_CNTW'(1);

  // Terminal count of the current prescaled period; every cycle at ratio 1.
  assign tick_o = (cnt_q == last_w);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      act_q <= '0;
      cnt_q <= '0;
      ph_q  <= 1'b1;
    end else if (tick_o) begin
      act_q <= code_i;
      cnt_q <= '0;
      ph_q  <= 1'b1;
    end else begin
      cnt_q <= cnt_inc_w;
      ph_q  <= (cnt_inc_w < half_w);
    end
  end

  // Ratio 1 forwards the master clock without a register stage.
  assign clk_o = (act_q == '0) ? clk_i : ph_q;

  // R8: the loaded code moves only on a terminal count.
  p_code_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_o |=> $stable(act_q));

  // R1: the phase counter stays inside the loaded ratio.
  p_cnt_bound_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= last_w);

endmodule

// File: rtl/clkdiv_ndiv.sv
module clkdiv_ndiv
  import clkdiv_pkg::*;
#(
  parameter int N_W = 10
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           adv_i,
  input  logic [N_W-1:0] code_i,
  output logic           clk_o
);

  // One extra bit so that ratio - 1 fits for the largest code.
  localparam int CW = N_W + 1;

  logic [N_W-1:0] act_q;
  logic [CW-1:0]  cnt_q;
  logic           ph_q;
  logic [CW-1:0]  last_w;
  logic [CW-1:0]  high_w;
  logic [CW-1:0]  cnt_inc_w;
  logic           term_w;

  assign last_w    = CW'(n_ratio(int'(act_q)) - 1);
  assign high_w    = CW'(n_high(int'(act_q)));
  assign cnt_inc_w = cnt_q + CW'(1);
  assign term_w    = adv_i && (cnt_q == last_w);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      act_q <= '0;
      cnt_q <= '0;
      ph_q  <= 1'b1;
    end else if (term_w) begin
      act_q <= code_i;
      cnt_q <= '0;
      ph_q  <= 1'b1;
    end else if (adv_i) begin
      cnt_q <= cnt_inc_w;
      ph_q  <= (cnt_inc_w < high_w);
    end
  end

  assign clk_o = ph_q;

  // R8: the divider code is loaded only at its terminal count.
  p_ncode_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !term_w |=> $stable(act_q));

  // R5: the period counter never reaches the divisor.
  p_cnt_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= last_w);

endmodule

// File: rtl/clkdiv_dual.sv
module clkdiv_dual
  import clkdiv_pkg::*;
#(
  parameter int N_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PRE_CW-1:0] ref_code_i,
  input  logic              ref_sel_i,
  input  logic [PRE_CW-1:0] main_code_i,
  input  logic [N_W-1:0]    n_code_i,
  input  logic              n_bypass_i,
  output logic              ref_clk_o,
  output logic              main_clk_o
);

  localparam int NPATH = 2;

  // Index 0 is the reference path, index 1 the main path.
  logic [PRE_CW-1:0] pre_code [NPATH];
  logic              pre_clk  [NPATH];
  logic              pre_tick [NPATH];
  logic              div_clk;
  logic              unused_ref_tick;

  assign pre_code[0] = ref_code_i;
  assign pre_code[1] = main_code_i;

  for (genvar i = 0; i < NPATH; i++) begin : g_pre
    clkdiv_prescaler u_pre (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .code_i (pre_code[i]),
      .clk_o  (pre_clk[i]),
      .tick_o (pre_tick[i])
    );
  end

  assign unused_ref_tick = pre_tick[0];

  // The divider counts whole prescaled periods, one per prescaler tick.
  clkdiv_ndiv #(.N_W(N_W)) u_ndiv (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (pre_tick[1]),
    .code_i (n_code_i),
    .clk_o  (div_clk)
  );

  assign ref_clk_o  = ref_sel_i  ? pre_clk[0] : clk_i;
  assign main_clk_o = n_bypass_i ? pre_clk[1] : div_clk;

  // R6: through the divider, the main clock moves only on a prescaler period boundary.
  p_main_on_tick_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!n_bypass_i && !pre_tick[1]) |=> (n_bypass_i || $stable(main_clk_o)));

endmodule

// File: tb/tb_clkdiv_dual.sv
module tb_clkdiv_dual;

  localparam int CLK_PERIOD = 10;
  localparam int GUARD      = 40000;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [1:0] ref_code_i = 2'd3;
  logic       ref_sel_i = 1'b1;
  logic [1:0] main_code_i = 2'd0;
  logic [9:0] n_code_i = 10'd5;
  logic       n_bypass_i = 1'b0;
  logic       ref_clk_o;
  logic       main_clk_o;

  int  n_checks = 0;
  int  n_fail = 0;
  bit  s_ref;
  bit  s_main;
  bit  done = 0;

  clkdiv_dual dut (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .ref_code_i  (ref_code_i),
    .ref_sel_i   (ref_sel_i),
    .main_code_i (main_code_i),
    .n_code_i    (n_code_i),
    .n_bypass_i  (n_bypass_i),
    .ref_clk_o   (ref_clk_o),
    .main_clk_o  (main_clk_o)
  );

  initial forever #(CLK_PERIOD/2) clk = ~clk;

  // Expected phase lengths in master cycles, derived from the requirements.
  function automatic int ratio_of(input int code);
    int m = 1;
    for (int k = 0; k < code; k++) m = m * 2;
    return m;
  endfunction

  function automatic int exp_hi(input int pc, input int nc, input bit byp);
    int m = ratio_of(pc);
    int n = nc + 2;
    if (byp) return m / 2;
    return m * (n - n / 2);
  endfunction

  function automatic int exp_lo(input int pc, input int nc, input bit byp);
    int m = ratio_of(pc);
    if (byp) return m / 2;
    return m * ((nc + 2) / 2);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Sample one quarter period after a rising edge, while the master clock is high.
  task automatic step();
    @(posedge clk);
    #(CLK_PERIOD/4);
    s_ref  = ref_clk_o;
    s_main = main_clk_o;
  endtask

  function automatic bit smp(input bit use_main);
    return use_main ? s_main : s_ref;
  endfunction

  // Continue from a high sample already counted in h, until the next rise.
  task automatic finish_period(input bit use_main, inout int h, output int l);
    int guard = 0;
    l = 0;
    step();
    while (smp(use_main) && guard < GUARD) begin h++; step(); guard++; end
    while (!smp(use_main) && guard < GUARD) begin l++; step(); guard++; end
  endtask

  task automatic measure(input bit use_main, output int h, output int l);
    int guard = 0;
    h = 0;
    l = 0;
    step();
    while (smp(use_main) && guard < GUARD) begin step(); guard++; end
    while (!smp(use_main) && guard < GUARD) begin step(); guard++; end
    if (guard >= GUARD) return;
    h = 1;
    finish_period(use_main, h, l);
  endtask

  // The output must be high in the first half of each cycle and low in the second.
  task automatic pt_check(input bit use_main, input string req);
    bit ok = 1'b1;
    for (int i = 0; i < 3; i++) begin
      step();
      if (!smp(use_main)) ok = 1'b0;
      #(CLK_PERIOD/2);
      if (use_main ? main_clk_o : ref_clk_o) ok = 1'b0;
    end
    check(ok, req, int'(ok), 1);
  endtask

  task automatic settle();
    repeat (12) step();
  endtask

  task automatic meas_check(input bit use_main, input string req, input int eh, input int el);
    int h, l;
    measure(use_main, h, l);
    check(h == eh, req, h, eh);
    check(l == el, req, l, el);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    if (!done) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin : stim
    int h, l;
    void'($urandom(32'h5eed));

    // Reset: the reference prescaler runs at ratio 1 although its code input is 11 (R1).
    repeat (3) @(posedge clk);
    pt_check(1'b0, "R1 reset code");
    check(main_clk_o == 1'b1, "R10 reset level", int'(main_clk_o), 1);

    // Release reset and check the first divide-by-2 period (R10).
    rst_ni = 1'b1;
    step();
    check(s_main == 1'b0, "R10 first edge", int'(s_main), 0);
    step();
    check(s_main == 1'b1, "R10 second edge", int'(s_main), 1);
    meas_check(1'b1, "R6 odd N=7", exp_hi(0, 5, 0), exp_lo(0, 5, 0));
    meas_check(1'b0, "R1 ratio 8", 4, 4);

    // Select 0 gives the master clock (R4).
    ref_sel_i = 1'b0;
    pt_check(1'b0, "R4 raw select");
    ref_sel_i = 1'b1;

    // Mid-period prescaler change: the current period finishes at ratio 8 (R8).
    measure(1'b0, h, l);
    h = 1;
    step();
    h += int'(s_ref);
    ref_code_i = 2'd1;
    finish_period(1'b0, h, l);
    check(h == 4, "R8 prescaler high", h, 4);
    check(l == 4, "R8 prescaler low", l, 4);
    meas_check(1'b0, "R8 prescaler new", 1, 1);
    ref_code_i = 2'd2;
    meas_check(1'b0, "R2 ratio 4", 2, 2);

    // Ratio 1 pass-through on both paths (R3).
    ref_code_i = 2'd0;
    settle();
    pt_check(1'b0, "R3 reference");
    n_bypass_i = 1'b1;
    main_code_i = 2'd0;
    settle();
    pt_check(1'b1, "R3 main bypass");

    // Bypass ignores the divider code (R7).
    main_code_i = 2'd2;
    n_code_i = 10'd3;
    meas_check(1'b1, "R7 bypass code 3", 2, 2);
    n_code_i = 10'd1023;
    meas_check(1'b1, "R7 bypass code 1023", 2, 2);

    // Divisor range ends (R5).
    n_bypass_i = 1'b0;
    main_code_i = 2'd0;
    n_code_i = 10'd0;
    meas_check(1'b1, "R5 min", 1, 1);
    meas_check(1'b1, "R5 min again", 1, 1);
    n_code_i = 10'd1023;
    meas_check(1'b1, "R5 max", exp_hi(0, 1023, 0), exp_lo(0, 1023, 0));
    main_code_i = 2'd3;
    meas_check(1'b1, "R5 max ratio 8", exp_hi(3, 1023, 0), exp_lo(3, 1023, 0));

    // Mid-period divider change from N=12 to N=2 (R8).
    main_code_i = 2'd0;
    n_code_i = 10'd10;
    meas_check(1'b1, "R6 even N=12", 6, 6);
    meas_check(1'b1, "R6 even N=12 again", 6, 6);
    h = 1;
    step();
    h += int'(s_main);
    step();
    h += int'(s_main);
    n_code_i = 10'd0;
    finish_period(1'b1, h, l);
    check(h == 6, "R8 divider high", h, 6);
    check(l == 6, "R8 divider low", l, 6);
    meas_check(1'b1, "R8 divider new", 1, 1);

    // Reference settings leave the main clock alone (R9).
    n_code_i = 10'd20;
    meas_check(1'b1, "R9 baseline", 11, 11);
    ref_code_i = 2'd1;
    ref_sel_i = 1'b0;
    meas_check(1'b1, "R9 after ref change", 11, 11);
    ref_sel_i = 1'b1;

    // Constrained random configurations on both paths (R2, R5, R6, R7, R9).
    for (int t = 0; t < 16; t++) begin
      int rc = $urandom_range(3, 1);
      int mc = $urandom_range(3, 0);
      int nc = $urandom_range(127, 0);
      bit byp = ($urandom_range(3, 0) == 0);
      if (byp && mc == 0) mc = 1;
      ref_code_i  = 2'(rc);
      main_code_i = 2'(mc);
      n_code_i    = 10'(nc);
      n_bypass_i  = byp;
      meas_check(1'b1, byp ? "R7 random" : "R5 R6 random",
                 exp_hi(mc, nc, byp), exp_lo(mc, nc, byp));
      meas_check(1'b0, "R2 R9 random", ratio_of(rc) / 2, ratio_of(rc) / 2);
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule